// File: doc/BRIEF.md
# Frame-Start and ID Search Controller

This block sits behind a clock-and-data recovery stage and decides whether an incoming transmission is meant for this receiver. An energy-detect pulse opens a search window. During the window the block accepts recovered bits one per strobe, hunts for a programmable start-of-frame byte, and then compares the field that follows against the receiver's own ID and a shared global ID. A match ends the search with an ID-match pulse. If the dwell window runs out first, a timeout pulse tells the surrounding receiver to fall back to idle.

The window length is programmed as a byte. Each unit of the byte is eight bit times, and bit times are counted from the accepted bit strobes. A window value of zero disables the timeout, so the search then runs until an ID match is found. The bit input is a valid/ready stream. The block raises ready only while a search is active, which is the only back-pressure it applies: bits offered while idle are not consumed and have no effect. While searching, ready stays high and every valid bit is taken in the cycle it is offered.

Top module: `frame_search`

## Requirements
- R1: After reset the block is idle. `searching`, `bit_ready`, `frame_found`, `id_match`, `id_global` and `search_timeout` are all low.
- R2: `bit_ready` is high exactly while a search is active. Bits offered while idle are not consumed and produce no `frame_found`, `id_match` or `search_timeout`.
- R3: An `energy_det` pulse while idle starts a search. `searching` and `bit_ready` are high in the next cycle, with the shift history and bit count cleared.
- R4: Bits are shifted in MSB first. When the 8 most recent accepted bits equal `sof_pattern`, and at least 8 bits have been accepted since the search started or the last field boundary, `frame_found` pulses for one cycle, in the cycle after the completing strobe.
- R5: After a start-of-frame match, the next ID_W accepted bits (MSB first) are compared with `own_id`. On equality, `id_match` pulses with `id_global` low, and the search ends.
- R6: If that field does not equal `own_id` but equals `global_id`, `id_match` and `id_global` pulse together and the search ends. `id_global` is never high without `id_match`.
- R7: If the ID field matches neither ID, no pulse is emitted and the block resumes hunting for the start-of-frame byte with a cleared history.
- R8: With `dwell_cfg` = N nonzero at the time of energy detection, if no ID match occurs, `search_timeout` pulses one cycle after the 8*N-th accepted strobe. The search then ends and all match state is cleared.
- R9: With `dwell_cfg` = 0 at energy detection, the search never times out.
- R10: An `energy_det` pulse during an active search reloads the window from `dwell_cfg`. The strobe count restarts, and the shift and match state is kept.
- R11: When the strobe that completes an ID match is also the last strobe of the window, the ID match wins and no timeout is emitted. A start-of-frame match on the last strobe of the window is overridden by the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| energy_det | input | 1 | One-cycle energy-detected pulse |
| bit_valid | input | 1 | Recovered bit strobe (stream valid) |
| bit_ready | output | 1 | High while a search accepts bits |
| bit_data | input | 1 | Recovered bit value |
| sof_pattern | input | 8 | Start-of-frame byte |
| own_id | input | ID_W | Receiver's own ID |
| global_id | input | ID_W | Shared global ID |
| dwell_cfg | input | 8 | Window length in units of 8 bit times, 0 = no timeout |
| searching | output | 1 | Search active |
| frame_found | output | 1 | One-cycle start-of-frame pulse |
| id_match | output | 1 | One-cycle ID match pulse |
| id_global | output | 1 | Qualifies `id_match` as a global-ID match |
| search_timeout | output | 1 | One-cycle window-expired pulse |

## Verification
Directed frames separate the three outcomes of the ID field: own ID, global ID and a foreign ID. A foreign ID must fall back to hunting rather than end the search. Window tests end exactly on the 8*N-th strobe and line up a completed ID with that same strobe, which exposes an off-by-one count and a wrong priority between match and timeout. Bits offered while idle, and a second energy pulse in mid-search, check that ready gates consumption and that the window reloads. Random episodes mix noise, gapped strobes, true and false start bytes, mid-stream energy pulses and both window modes. A bench model checks every cycle's outputs against them.

// File: rtl/frame_search_pkg.sv
package frame_search_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HUNT = 2'd1,
    FS_IDF  = 2'd2
  } fs_state_t;

  localparam int unsigned SOF_W   = 8;
  localparam int unsigned DWELL_W = 8;
  localparam int unsigned BT_SHIFT = 3;
endpackage

// File: rtl/frame_search_shift.sv
module frame_search_shift #(
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic          din,
  output logic [SW-1:0] nxt_word,
  output logic [$clog2(SW+1)-1:0] nxt_fill
);
  localparam int unsigned FW = $clog2(SW + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(SW);

  logic [SW-1:0] word_q;
  logic [FW-1:0] fill_q;

  assign nxt_word = {word_q[SW-2:0], din};
  assign nxt_fill = (fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      fill_q <= '0;
    end else if (clr) begin
      word_q <= '0;
      fill_q <= '0;
    end else if (shift) begin
      word_q <= nxt_word;
      fill_q <= nxt_fill;
    end
  end
endmodule

// File: rtl/frame_search_dwell.sv
module frame_search_dwell #(
  parameter int unsigned DWW = 8,
  parameter int unsigned BTS = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [DWW-1:0] dwell,
  input  logic           tick,
  output logic           expire
);
  localparam int unsigned CW = DWW + BTS;

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign expire = tick && armed_q && !load && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= {dwell, {BTS{1'b0}}};
      armed_q <= (dwell != '0);
    end else if (tick && armed_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_search.sv
module frame_search
  import frame_search_pkg::*;
#(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            energy_det,
  input  logic            bit_valid,
  output logic            bit_ready,
  input  logic            bit_data,
  input  logic [7:0]      sof_pattern,
  input  logic [ID_W-1:0] own_id,
  input  logic [ID_W-1:0] global_id,
  input  logic [7:0]      dwell_cfg,
  output logic            searching,
  output logic            frame_found,
  output logic            id_match,
  output logic            id_global,
  output logic            search_timeout
);
  localparam int unsigned SW = (ID_W > SOF_W) ? ID_W : SOF_W;
  localparam int unsigned FW = $clog2(SW + 1);
  localparam logic [FW-1:0] SOF_LEN = FW'(SOF_W);
  localparam logic [FW-1:0] ID_LEN  = FW'(ID_W);

  fs_state_t     state_q, state_d;
  logic          acc;
  logic          clr;
  logic [SW-1:0] nxt_word;
  logic [FW-1:0] nxt_fill;
  logic          expire;
  logic          sof_hit, id_done, own_hit, glob_hit;
  logic          ff_d, idm_d, idg_d, to_d;

  assign searching = (state_q != FS_IDLE);
  assign bit_ready = searching;
  assign acc       = bit_valid && searching;

  frame_search_shift #(.SW(SW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift    (acc),
    .din      (bit_data),
    .nxt_word (nxt_word),
    .nxt_fill (nxt_fill)
  );

  frame_search_dwell #(.DWW(DWELL_W), .BTS(BT_SHIFT)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (energy_det),
    .dwell  (dwell_cfg),
    .tick   (acc),
    .expire (expire)
  );

  assign sof_hit  = acc && (state_q == FS_HUNT) && (nxt_fill >= SOF_LEN) &&
                    (nxt_word[SOF_W-1:0] == sof_pattern);
  assign id_done  = acc && (state_q == FS_IDF) && (nxt_fill == ID_LEN);
  assign own_hit  = id_done && (nxt_word[ID_W-1:0] == own_id);
  assign glob_hit = id_done && !own_hit && (nxt_word[ID_W-1:0] == global_id);

  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    ff_d    = 1'b0;
    idm_d   = 1'b0;
    idg_d   = 1'b0;
    to_d    = 1'b0;
    if (state_q == FS_IDLE) begin
      if (energy_det) begin
        state_d = FS_HUNT;
        clr     = 1'b1;
      end
    end else if (own_hit || glob_hit) begin
      state_d = FS_IDLE;
      clr     = 1'b1;
      idm_d   = 1'b1;
      idg_d   = glob_hit;
    end else if (expire) begin
      state_d = FS_IDLE;
      clr     = 1'b1;
      to_d    = 1'b1;
    end else if (sof_hit) begin
      state_d = FS_IDF;
      clr     = 1'b1;
      ff_d    = 1'b1;
    end else if (id_done) begin
      state_d = FS_HUNT;
      clr     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= FS_IDLE;
      frame_found    <= 1'b0;
      id_match       <= 1'b0;
      id_global      <= 1'b0;
      search_timeout <= 1'b0;
    end else begin
      state_q        <= state_d;
      frame_found    <= ff_d;
      id_match       <= idm_d;
      id_global      <= idg_d;
      search_timeout <= to_d;
    end
  end
endmodule

// File: rtl/frame_search_chk.sv
module frame_search_chk (
  input logic clk,
  input logic rst_n,
  input logic energy_det,
  input logic bit_valid,
  input logic bit_ready,
  input logic searching,
  input logic frame_found,
  input logic id_match,
  input logic id_global,
  input logic search_timeout
);
  p_energy_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    energy_det |=> searching);
  p_sof_pulse_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_found |=> !frame_found);
  p_global_qualifies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_global |-> id_match);
  p_match_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_match |-> !searching);
  p_timeout_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    search_timeout |-> !searching);
  p_timeout_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    search_timeout |-> $past(bit_valid && bit_ready && !energy_det));
  p_pulses_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_found, id_match, search_timeout}));
  p_idle_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(searching) |-> !(frame_found || id_match || search_timeout));
endmodule

bind frame_search frame_search_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .energy_det     (energy_det),
  .bit_valid      (bit_valid),
  .bit_ready      (bit_ready),
  .searching      (searching),
  .frame_found    (frame_found),
  .id_match       (id_match),
  .id_global      (id_global),
  .search_timeout (search_timeout)
);

// File: tb/sim_frame_search.sv
`timescale 1ns/1ps
module sim_frame_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic energy_det = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic [7:0] sof_pattern = 8'h55, own_id = 8'hA3, global_id = 8'hFF, dwell_cfg = 8'h00;
  logic bit_ready, searching, frame_found, id_match, id_global, search_timeout;

  int checks = 0, errors = 0;
  int n_ff = 0, n_id = 0, n_to = 0;
  logic last_ff, last_id, last_g, last_to;
  bit done = 0;

  // bench model state
  bit m_srch = 0, m_phase = 0, m_en = 0;
  logic [7:0] m_sh = 0;
  int m_fill = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  frame_search #(.ID_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .energy_det(energy_det), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .sof_pattern(sof_pattern),
    .own_id(own_id), .global_id(global_id), .dwell_cfg(dwell_cfg),
    .searching(searching), .frame_found(frame_found), .id_match(id_match),
    .id_global(id_global), .search_timeout(search_timeout));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare after the edge
  task automatic cyc(input bit e, input bit v, input bit d);
    bit acc, exp_ff, exp_id, exp_g, exp_to, expire, hit;
    logic [7:0] nsh;
    int nfill;
    @(negedge clk);
    energy_det = e; bit_valid = v; bit_data = d;
    #0.5;
    chk("R2 ready", bit_ready, m_srch);
    acc = v && m_srch;
    exp_ff = 0; exp_id = 0; exp_g = 0; exp_to = 0;
    expire = acc && m_en && (m_cnt == 1) && !e;
    if (!m_srch) begin
      if (e) begin m_srch = 1; m_phase = 0; m_sh = 0; m_fill = 0; end
    end else if (acc) begin
      nsh = {m_sh[6:0], d};
      nfill = (m_fill < 8) ? m_fill + 1 : 8;
      hit = 0;
      if (m_phase == 1 && nfill == 8) begin
        if (nsh == own_id) begin exp_id = 1; hit = 1; end
        else if (nsh == global_id) begin exp_id = 1; exp_g = 1; hit = 1; end
      end
      if (hit) begin m_srch = 0; m_sh = 0; m_fill = 0; end
      else if (expire) begin exp_to = 1; m_srch = 0; m_sh = 0; m_fill = 0; m_phase = 0; end
      else if (m_phase == 0 && nfill >= 8 && nsh == sof_pattern) begin
        exp_ff = 1; m_phase = 1; m_sh = 0; m_fill = 0;
      end else if (m_phase == 1 && nfill == 8) begin
        m_phase = 0; m_sh = 0; m_fill = 0;
      end else begin m_sh = nsh; m_fill = nfill; end
    end
    if (e) begin m_cnt = int'(dwell_cfg) * 8; m_en = (dwell_cfg != 0); end
    else if (acc && m_en) begin m_cnt--; if (m_cnt == 0) m_en = 0; end
    @(posedge clk); #1;
    last_ff = frame_found; last_id = id_match; last_g = id_global; last_to = search_timeout;
    n_ff += int'(frame_found); n_id += int'(id_match); n_to += int'(search_timeout);
    chk("R4 frame_found", frame_found, exp_ff);
    chk("R5 id_match", id_match, exp_id);
    chk("R6 id_global", id_global, exp_g);
    chk("R8 search_timeout", search_timeout, exp_to);
    chk("R3 searching", searching, m_srch);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gaps);
    for (int i = 7; i >= 0; i--) begin
      if (gaps) while ($urandom % 4 == 0) cyc(0, 0, 0);
      cyc(0, 1, b[i]);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  initial begin
    int base_ff, base_id, base_to;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 searching", searching, 0);
    chk("R1 bit_ready", bit_ready, 0);
    chk("R1 pulses", int'({frame_found, id_match, id_global, search_timeout}), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: bits while idle are not consumed
    base_ff = n_ff;
    send_byte(8'h55, 0);
    send_byte(8'hA3, 0);
    chk("R2 idle bits ignored", n_ff + n_id + n_to - base_ff, 0);

    // R3 R4 R5: own ID frame, no window
    dwell_cfg = 0; base_id = n_id;
    cyc(1, 0, 0);
    chk("R3 search started", searching, 1);
    cyc(0, 1, 1); cyc(0, 1, 0);
    send_byte(8'h55, 0);
    chk("R4 sof pulse after last bit", last_ff, 1);
    send_byte(8'hA3, 0);
    chk("R5 own id match", last_id, 1);
    chk("R5 not global", last_g, 0);
    chk("R5 search ended", searching, 0);

    // R6 global ID, R7 foreign ID resumes hunting
    cyc(1, 0, 0);
    send_byte(8'h55, 0); send_byte(8'h3C, 0);
    chk("R7 foreign id no match", last_id, 0);
    chk("R7 still searching", searching, 1);
    send_byte(8'h55, 0); send_byte(8'hFF, 0);
    chk("R6 global match", last_id & last_g, 1);

    // R8: window 1 -> 8 strobes
    dwell_cfg = 8'd1; base_to = n_to;
    cyc(1, 0, 0);
    send_byte(8'h0F, 1);
    chk("R8 timeout after 8 strobes", last_to, 1);
    chk("R8 idle after timeout", searching, 0);

    // R10: energy mid-search reloads window
    dwell_cfg = 8'd1;
    cyc(1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0);
    cyc(1, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 1, 0);
    chk("R10 no timeout after reload", n_to - base_to, 1);
    cyc(0, 1, 0);
    chk("R10 timeout at reloaded end", last_to, 1);

    // R11: ID completes on final strobe of a 16-strobe window
    dwell_cfg = 8'd2; base_to = n_to;
    cyc(1, 0, 0);
    send_byte(8'h55, 0); send_byte(8'hA3, 0);
    chk("R11 match wins", last_id, 1);
    chk("R11 no timeout", n_to - base_to, 0);
    // R11: SOF on final strobe loses to timeout
    dwell_cfg = 8'd1; base_ff = n_ff;
    cyc(1, 0, 0);
    send_byte(8'h55, 0);
    chk("R11 timeout over sof", last_to, 1);
    chk("R11 sof suppressed", n_ff - base_ff, 0);

    // R9: window 0 never times out
    dwell_cfg = 0; base_to = n_to;
    cyc(1, 0, 0);
    for (int i = 0; i < 3000; i++) cyc(0, 1, 1'(i % 3 == 0));
    chk("R9 no timeout", n_to - base_to, 0);
    chk("R9 still searching", searching, 1);
    send_byte(8'h55, 0); send_byte(8'hA3, 0);
    idle(2);

    // random episodes
    for (int ep = 0; ep < 200; ep++) begin
      int sel;
      logic [7:0] idv;
      sof_pattern = ($urandom % 2) ? 8'h55 : 8'h0A;
      own_id = 8'($urandom); global_id = 8'($urandom);
      sel = $urandom % 5;
      dwell_cfg = (sel == 0) ? 8'd0 : 8'(sel);
      cyc(1, 0, 0);
      for (int i = 0; i < int'($urandom % 10); i++) begin
        bit ee;
        ee = ($urandom % 30 == 0);
        cyc(ee, 1'($urandom % 4 != 0), 1'($urandom));
      end
      send_byte(($urandom % 4 == 0) ? 8'($urandom) : sof_pattern, 1);
      sel = $urandom % 3;
      idv = (sel == 0) ? own_id : (sel == 1) ? global_id : 8'($urandom);
      send_byte(idv, 1);
      for (int i = 0; i < 6; i++) cyc(0, 1, 1'($urandom));
      idle(1 + $urandom % 3);
    end
    done = 1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 150000) begin @(posedge clk); cycles++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule